// File: doc/BRIEF.md
# Receive Buffer with Watermark Drain Control

This block holds words read from a serial flash until the host collects them. A read engine pushes one data word per beat, and the host takes words from the head through a pop strobe. The block keeps a count of valid entries and compares it with a programmable watermark. The result drives a drain status flag, which a host interrupt path or a DMA request can use. A sticky overflow flag records words that arrived while the buffer was full. Such words are dropped, and the read that produced them goes on to its end.

A per-command byte budget is loaded when a read starts. Every word the engine delivers uses up its bytes, whether the word is stored or dropped. The busy output stays high until the budget reaches zero. Writing 1 to the drain flag acts in one of two ways. If the fill level is at or below the watermark, the write clears the flag. If the level is above it, the write pops one word, unless DMA mode is selected. After that pop the flag again follows the level.

Top module: `rx_wm_fifo`

## Requirements
- R1: After reset, level is 0, drain_flag, ovf_flag, dma_req and xfer_busy are all 0.
- R2: Stored words leave in arrival order; pop_data always shows the oldest entry; level updates one clock after a push or pop.
- R3: A push while level equals DEPTH is discarded and sets ovf_flag one clock later; the words already held, and their order, are unchanged.
- R4: xfer_start loads the byte budget; each push seen while xfer_busy is 1 consumes 4 bytes (the final partial word uses the remainder). xfer_busy is 1 while budget is nonzero, an overflow does not end it, and a push while xfer_busy is 0 is ignored.
- R5: drain_flag is 1 in the clock after level becomes greater than wmark, and it stays 1 while level remains above wmark.
- R6: A write of 1 to drain_flag (drain_w1) while level is at or below wmark clears the flag and pops nothing.
- R7: With dma_mode 0, drain_w1 while level is above wmark pops one word instead of clearing; afterwards drain_flag is 1 only if the new level is still above wmark.
- R8: With dma_mode 1, drain_w1 pops nothing, and dma_req is 1 exactly while level is above wmark.
- R9: ovf_w1 clears ovf_flag; if an overflow happens in the same clock, the flag stays set.
- R10: A push and a pop in the same clock leave level unchanged; a pop on an empty buffer does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Start of a read command; loads xfer_bytes |
| xfer_bytes | input | XFER_W | Byte count of the read command |
| xfer_busy | output | 1 | Byte budget not yet used up |
| push_valid | input | 1 | Read engine delivers a word |
| push_data | input | DATA_W | Delivered word |
| host_pop | input | 1 | Host takes the head word |
| pop_data | output | DATA_W | Head word |
| level | output | CNT_W | Valid-entry count |
| wmark | input | CNT_W | Watermark, at most DEPTH |
| dma_mode | input | 1 | 0: flag-driven drain, 1: DMA-driven drain |
| drain_w1 | input | 1 | Host writes 1 to the drain flag |
| ovf_w1 | input | 1 | Host writes 1 to the overflow flag |
| drain_flag | output | 1 | Drain status flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| dma_req | output | 1 | DMA drain request |

## Verification
Level, both flags and xfer_busy come from registers. They change on the first rising edge after the stimulus is presented. pop_data and dma_req are combinational from that registered state, so they settle in the same cycle. The bench applies every stimulus on a falling edge and holds it across exactly one rising edge. It removes the stimulus on the next falling edge and checks all outputs there, half a period after the edge that updated them. A sweep over every watermark and fill level from 0 to 16 fixes the expected level and flag values with simple arithmetic before and after each drain write, in both modes.

// File: rtl/rx_wm_pkg.sv
package rx_wm_pkg;

   typedef enum logic {
      DRAIN_BY_FLAG = 1'b0,
      DRAIN_BY_DMA  = 1'b1
   } drain_mode_e;

   function automatic int bytes_per_word(input int data_w);
      return data_w / 8;
   endfunction

endpackage

// File: rtl/rx_wm_store.sv
module rx_wm_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);

   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_inc, rd_ptr_inc;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_ptr_inc = wr_ptr + 1'b1;
         assign rd_ptr_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_ptr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr_inc;
         if (rd_en) rd_ptr <= rd_ptr_inc;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/rx_wm_level.sv
module rx_wm_level #(
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic             rd_ok,
   input  logic [CNT_W-1:0] wmark,
   input  logic             drain_w1,
   input  logic             ovf_evt,
   input  logic             ovf_w1,
   output logic [CNT_W-1:0] level,
   output logic             drain_flag,
   output logic             ovf_flag
);

   logic [CNT_W-1:0] level_nxt;

   always_comb begin
      level_nxt = level;
      if (wr_ok && !rd_ok) level_nxt = level + 1'b1;
      if (rd_ok && !wr_ok) level_nxt = level - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level      <= '0;
         drain_flag <= 1'b0;
         ovf_flag   <= 1'b0;
      end else begin
         level      <= level_nxt;
         drain_flag <= (level_nxt > wmark) | (drain_flag & ~drain_w1);
         ovf_flag   <= ovf_evt | (ovf_flag & ~ovf_w1);
      end
   end

endmodule

// File: rtl/rx_wm_xfer.sv
module rx_wm_xfer #(
   parameter int XFER_W = 16,
   parameter int BPW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [XFER_W-1:0] bytes,
   input  logic              beat,
   output logic              busy
);

   logic [XFER_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (start) begin
         remain <= bytes;
      end else if (beat && remain != '0) begin
         remain <= (remain > XFER_W'(BPW)) ? remain - XFER_W'(BPW) : '0;
      end
   end

   assign busy = (remain != '0);

endmodule

// File: rtl/rx_wm_fifo.sv
module rx_wm_fifo
   import rx_wm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int XFER_W = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic [XFER_W-1:0] xfer_bytes,
   output logic              xfer_busy,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              host_pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  level,
   input  logic [CNT_W-1:0]  wmark,
   input  logic              dma_mode,
   input  logic              drain_w1,
   input  logic              ovf_w1,
   output logic              drain_flag,
   output logic              ovf_flag,
   output logic              dma_req
);

   localparam int BPW = bytes_per_word(DATA_W);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         initial $error("rx_wm_fifo: DATA_W must be a whole number of bytes");
      end
      if (DEPTH < 2) begin : g_bad_depth
         initial $error("rx_wm_fifo: DEPTH must be at least 2");
      end
      if (XFER_W < 2) begin : g_bad_xfer
         initial $error("rx_wm_fifo: XFER_W too small");
      end
   endgenerate

   drain_mode_e mode;
   logic        full, empty, above, drain_pop, wr_ok, rd_ok, ovf_evt, beat;

   assign mode      = drain_mode_e'(dma_mode);
   assign full      = (level == CNT_W'(DEPTH));
   assign empty     = (level == '0);
   assign above     = (level > wmark);
   assign beat      = push_valid && xfer_busy;
   assign drain_pop = drain_w1 && above && (mode == DRAIN_BY_FLAG);
   assign rd_ok     = (host_pop || drain_pop) && !empty;
   assign wr_ok     = beat && !full;
   assign ovf_evt   = beat && full;
   assign dma_req   = (mode == DRAIN_BY_DMA) && above;

   rx_wm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_data (push_data),
      .rd_en   (rd_ok),
      .rd_data (pop_data)
   );

   rx_wm_level #(.DEPTH(DEPTH)) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ok      (wr_ok),
      .rd_ok      (rd_ok),
      .wmark      (wmark),
      .drain_w1   (drain_w1),
      .ovf_evt    (ovf_evt),
      .ovf_w1     (ovf_w1),
      .level      (level),
      .drain_flag (drain_flag),
      .ovf_flag   (ovf_flag)
   );

   rx_wm_xfer #(.XFER_W(XFER_W), .BPW(BPW)) u_xfer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (xfer_start),
      .bytes (xfer_bytes),
      .beat  (push_valid),
      .busy  (xfer_busy)
   );

endmodule

// File: rtl/rx_wm_fifo_chk.sv
module rx_wm_fifo_chk #(
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xfer_start,
   input logic             xfer_busy,
   input logic             push_valid,
   input logic             host_pop,
   input logic [CNT_W-1:0] level,
   input logic [CNT_W-1:0] wmark,
   input logic             dma_mode,
   input logic             drain_w1,
   input logic             ovf_w1,
   input logic             drain_flag,
   input logic             ovf_flag,
   input logic             dma_req
);

   assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));

   assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (level == CNT_W'(DEPTH) && push_valid && xfer_busy && !host_pop && !drain_w1)
      |=> (level == CNT_W'(DEPTH) && ovf_flag));

   assert_idle_stays_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_busy && !xfer_start) |=> !xfer_busy);

   assert_flag_follows_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (level > wmark && $stable(wmark)) |-> drain_flag);

   assert_dma_write_no_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_mode && drain_w1 && !host_pop && !push_valid) |=> $stable(level));

   assert_dma_req_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && $stable(wmark)) |-> drain_flag);

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_w1) |=> ovf_flag);

endmodule

bind rx_wm_fifo rx_wm_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_start (xfer_start),
   .xfer_busy  (xfer_busy),
   .push_valid (push_valid),
   .host_pop   (host_pop),
   .level      (level),
   .wmark      (wmark),
   .dma_mode   (dma_mode),
   .drain_w1   (drain_w1),
   .ovf_w1     (ovf_w1),
   .drain_flag (drain_flag),
   .ovf_flag   (ovf_flag),
   .dma_req    (dma_req)
);

// File: tb/test_rx_wm_fifo.sv
module test_rx_wm_fifo;

   localparam int DATA_W = 32;
   localparam int DEPTH  = 16;
   localparam int XFER_W = 16;
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam logic [31:0] BASE = 32'hA500_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              xfer_start = 1'b0;
   logic [XFER_W-1:0] xfer_bytes = '0;
   logic              xfer_busy;
   logic              push_valid = 1'b0;
   logic [DATA_W-1:0] push_data = '0;
   logic              host_pop = 1'b0;
   logic [DATA_W-1:0] pop_data;
   logic [CNT_W-1:0]  level;
   logic [CNT_W-1:0]  wmark = '0;
   logic              dma_mode = 1'b0;
   logic              drain_w1 = 1'b0;
   logic              ovf_w1 = 1'b0;
   logic              drain_flag;
   logic              ovf_flag;
   logic              dma_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rx_wm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .XFER_W(XFER_W)) i_rx_wm_fifo (.*);

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one rising edge with current inputs, then release strobes; outputs sampled on the falling edge
   task automatic cycle();
      @(negedge clk);
      xfer_start = 1'b0; push_valid = 1'b0; host_pop = 1'b0;
      drain_w1 = 1'b0; ovf_w1 = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic start(input int nbytes);
      xfer_start = 1'b1; xfer_bytes = XFER_W'(nbytes);
      cycle();
   endtask

   task automatic push(input int k);
      push_valid = 1'b1; push_data = BASE + 32'(k);
      cycle();
   endtask

   initial begin
      do_reset();
      // R1 reset state
      check("R1 level", level, 0);
      check("R1 drain_flag", drain_flag, 0);
      check("R1 ovf_flag", ovf_flag, 0);
      check("R1 dma_req", dma_req, 0);
      check("R1 xfer_busy", xfer_busy, 0);

      // R5 R6 R7 R8: sweep watermark and fill level in both modes
      for (int md = 0; md < 2; md++) begin
         for (int wm = 0; wm <= DEPTH; wm++) begin
            for (int n = 0; n <= DEPTH; n++) begin
               do_reset();
               wmark = CNT_W'(wm); dma_mode = md[0];
               start(4 * DEPTH);
               for (int k = 0; k < n; k++) push(k);
               check("R2 level after fill", level, n);
               check("R5 drain_flag after fill", drain_flag, n > wm);
               check("R8 dma_req after fill", dma_req, (md == 1) && (n > wm));
               drain_w1 = 1'b1;
               cycle();
               if (md == 0 && n > wm) begin
                  check("R7 level after drain pop", level, n - 1);
                  check("R7 drain_flag after pop", drain_flag, (n - 1) > wm);
                  if (n >= 2) check("R2 head after drain pop", pop_data, BASE + 32'd1);
               end else if (n > wm) begin
                  check("R8 level kept in dma mode", level, n);
                  check("R8 drain_flag kept", drain_flag, 1);
                  check("R8 dma_req kept", dma_req, 1);
               end else begin
                  check("R6 level kept", level, n);
                  check("R6 drain_flag cleared", drain_flag, 0);
               end
            end
         end
      end
      dma_mode = 1'b0;

      // R5: flag stays set while above, host pops do not clear it when still above
      do_reset();
      wmark = CNT_W'(3);
      start(64);
      for (int k = 0; k < 6; k++) push(k);
      host_pop = 1'b1; cycle();
      check("R5 flag held above wmark", drain_flag, 1);

      // R3 R4 R9: overflow run
      do_reset();
      wmark = CNT_W'(DEPTH);
      start(4 * (DEPTH + 4));
      for (int k = 0; k < DEPTH; k++) push(k);
      check("R3 full level", level, DEPTH);
      check("R3 no overflow yet", ovf_flag, 0);
      push(100);
      check("R3 overflow flag set", ovf_flag, 1);
      check("R3 level unchanged", level, DEPTH);
      check("R4 busy through overflow", xfer_busy, 1);
      push(101);
      ovf_w1 = 1'b1; push(102);
      check("R9 set wins over clear", ovf_flag, 1);
      check("R4 busy before last word", xfer_busy, 1);
      push(103);
      check("R4 done after last word", xfer_busy, 0);
      ovf_w1 = 1'b1; cycle();
      check("R9 overflow cleared", ovf_flag, 0);
      for (int k = 0; k < DEPTH; k++) begin
         check("R3 stored data intact", pop_data, BASE + 32'(k));
         host_pop = 1'b1; cycle();
      end
      check("R2 drained", level, 0);

      // R4: partial last word and idle pushes ignored
      do_reset();
      start(10);
      push(0); check("R4 busy after 4 bytes", xfer_busy, 1);
      push(1); check("R4 busy after 8 bytes", xfer_busy, 1);
      push(2); check("R4 idle after 10 bytes", xfer_busy, 0);
      push(3); check("R4 idle push ignored", level, 3);

      // R10: simultaneous push and pop; pop on empty
      do_reset();
      start(64);
      for (int k = 0; k < 5; k++) push(k);
      host_pop = 1'b1; push(5);
      check("R10 level unchanged", level, 5);
      check("R10 head advanced", pop_data, BASE + 32'd1);
      do_reset();
      host_pop = 1'b1; cycle();
      check("R10 pop on empty", level, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule